// File: doc/BRIEF.md
# Control Source Mode Detector

This block sits at the control edge of a two-carrier TV sound decoder. It watches a single enable line and works out which kind of controller drives the part. If the line is held low, a two-wire serial bus is in charge. If it carries short high pulses, a strobed three-wire microcontroller link is in charge. If it is held high, two plain logic levels pick the audio matrix mode directly. The two shared lines act as clock and data in the serial cases and as static logic levels in the direct case.

In direct mode the block decodes the two line levels into one of the four matrix modes. In strobed mode it shifts in a 24-bit write frame while the enable line is high. When the strobe ends, it checks the frame and updates the matrix mode or the mute bit. A strobe that stays high too long is taken as a sign that the controller is gone, and the block falls back to direct control. The serial bus protocol itself is handled elsewhere. In bus mode this block only holds the last settings.

All inputs pass through synchronizers, and every time window below is counted in clock cycles after synchronization. `STROBE_MAX_CYC` stands for the 6 ms strobe limit scaled to the clock. `STABLE_CYC` is the time a low level must persist before bus control is declared.

Top module: `ctl_src_detect`

## Requirements
- R1: After reset, the control source is direct (`src_o` = 2), the matrix mode is mono (`matrix_mode_o` = 0) and mute is off.
- R2: In direct mode, the enable line held low for `STABLE_CYC` consecutive cycles switches the source to bus (`src_o` = 0). A shorter low interval leaves the source at direct.
- R3: In bus or strobed mode, the enable line high for more than `STROBE_MAX_CYC` consecutive cycles switches the source to direct. A frame carried by such a pulse is never applied.
- R4: A high pulse of 1 to `STROBE_MAX_CYC` cycles, seen in bus or strobed mode, selects strobed mode (`src_o` = 1) when it ends. Direct mode never moves straight to strobed mode.
- R5: In direct mode, `{line_a_i, line_b_i}` sets the matrix mode as follows: 00 gives mono (0), 10 gives stereo (1), 01 gives bilingual (2) and 11 gives sub (3). Mute is held off in direct mode.
- R6: In strobed mode, `line_b_i` is sampled on each rising edge of `line_a_i` while the enable line is high. A frame is 24 bits, MSB first, in this order:
  - a 7-bit select code 1000010;
  - a direction bit, which must be 0 (write);
  - a sub-address byte, whose top three bits pick the function;
  - a data byte.
- R7: For sub-address function 000, the first two data bits (D1 then D2) set the matrix mode with the same mapping as R5.
- R8: For sub-address function 001, the first data bit sets the mute output (1 = muted).
- R9: A frame is discarded without any output change when any of these holds: the select code is wrong, the direction bit is 1, the bit count is not 24, or the function is not 000 or 001.
- R10: Outside direct mode, the matrix mode and the mute bit change only through an accepted frame. Activity on the shared lines while the enable line is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable / strobe line |
| line_a_i | input | 1 | Shared line: serial clock, or first direct logic level |
| line_b_i | input | 1 | Shared line: serial data, or second direct logic level |
| src_o | output | 2 | Detected control source: 0 bus, 1 strobed, 2 direct |
| matrix_mode_o | output | 2 | Matrix mode: 0 mono, 1 stereo, 2 bilingual, 3 sub |
| mute_o | output | 1 | Audio mute |

## Verification
The hardest situation to reach is the edge of the strobe window. A full, valid frame must arrive on a pulse exactly `STROBE_MAX_CYC` cycles long and be accepted. The same frame on a pulse one cycle longer must instead drop the block into direct mode.

The stimulus produces both cases from one frame-sending task. The task pads the strobe with a chosen number of idle cycles after the last data bit, so the pulse length is exact in clock cycles. The pad value is computed from the fixed per-bit timing.

The bench also walks the block through every source transition. This includes returning to bus mode after a fallback, so that the clearing of mute in direct mode can be seen.

// File: rtl/ctl_src_pkg.sv
`timescale 1ns/1ps
package ctl_src_pkg;

  typedef enum logic [1:0] {
    SRC_BUS    = 2'd0,
    SRC_STROBE = 2'd1,
    SRC_DC     = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    MX_MONO   = 2'd0,
    MX_STEREO = 2'd1,
    MX_BILING = 2'd2,
    MX_SUB    = 2'd3
  } mx_e;

  localparam int unsigned FRAME_BITS = 24;
  localparam logic [6:0]  SEL_CODE   = 7'b1000010;
  localparam logic [2:0]  FN_MODE    = 3'b000;
  localparam logic [2:0]  FN_MUTE    = 3'b001;

  // first/second bit pair to matrix mode (shared by direct and frame paths)
  function automatic mx_e pair_to_mode(input logic first_bit, input logic second_bit);
    mx_e m;
    case ({first_bit, second_bit})
      2'b10:   m = MX_STEREO;
      2'b01:   m = MX_BILING;
      2'b11:   m = MX_SUB;
      default: m = MX_MONO;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ctl_sync.sv
`timescale 1ns/1ps
module ctl_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_rest
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/ctl_level_track.sv
`timescale 1ns/1ps
module ctl_level_track #(
  parameter int unsigned STROBE_MAX_CYC = 64,
  parameter int unsigned STABLE_CYC     = 160,
  parameter int unsigned CNT_W          = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic short_end_o,
  output logic long_hi_o,
  output logic low_stable_o
);

  localparam logic [CNT_W-1:0] MAX_C    = CNT_W'(STROBE_MAX_CYC);
  localparam logic [CNT_W-1:0] STABLE_C = CNT_W'(STABLE_CYC);
  localparam logic [CNT_W-1:0] LOW_C    = CNT_W'(STABLE_CYC - 1);

  logic             lvl_q;
  logic [CNT_W-1:0] run_q, run_d;
  logic             fall_w;

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_w = ~lvl_i & lvl_q;

  always_comb begin
    if (lvl_i != lvl_q)        run_d = CNT_W'(1);
    else if (run_q != STABLE_C) run_d = run_q + CNT_W'(1);
    else                        run_d = run_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else begin
      lvl_q <= lvl_i;
      run_q <= run_d;
    end
  end

  // run_q holds the length of the run that ended when a fall is seen
  assign short_end_o  = fall_w & (run_q <= MAX_C);
  assign long_hi_o    = lvl_i & lvl_q & (run_q >= MAX_C);
  assign low_stable_o = ~lvl_i & ~lvl_q & (run_q >= LOW_C);

endmodule

// File: rtl/ctl_strobe_rx.sv
`timescale 1ns/1ps
module ctl_strobe_rx
  import ctl_src_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic en_rise_i,
  input  logic sclk_i,
  input  logic sdat_i,
  output logic frame_ok_o,
  output logic mode_cmd_o,
  output mx_e  mode_val_o,
  output logic mute_cmd_o,
  output logic mute_val_o
);

  localparam int unsigned BC_W = $clog2(FRAME_BITS + 2);
  localparam logic [BC_W-1:0] FULL_C = BC_W'(FRAME_BITS);
  localparam logic [BC_W-1:0] OVER_C = BC_W'(FRAME_BITS + 1);

  logic                  sclk_q;
  logic                  sclk_rise;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [BC_W-1:0]       cnt_q, cnt_d;

  assign sclk_rise = sclk_i & ~sclk_q;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (en_rise_i) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (en_i && sclk_rise) begin
      sr_d = {sr_q[FRAME_BITS-2:0], sdat_i};
      if (cnt_q != OVER_C) cnt_d = cnt_q + BC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sr_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_q <= sclk_i;
      sr_q   <= sr_d;
      cnt_q  <= cnt_d;
    end
  end

  logic [6:0] sel_f;
  logic       dir_f;
  logic [2:0] fn_f;
  logic       unused_bits;

  assign sel_f       = sr_q[23:17];
  assign dir_f       = sr_q[16];
  assign fn_f        = sr_q[15:13];
  assign unused_bits = ^{sr_q[12:8], sr_q[5:0]};

  assign frame_ok_o = (cnt_q == FULL_C) && (sel_f == SEL_CODE) && !dir_f;
  assign mode_cmd_o = (fn_f == FN_MODE);
  assign mute_cmd_o = (fn_f == FN_MUTE);
  assign mode_val_o = pair_to_mode(sr_q[7], sr_q[6]);
  assign mute_val_o = sr_q[7];

endmodule

// File: rtl/ctl_src_fsm.sv
`timescale 1ns/1ps
module ctl_src_fsm
  import ctl_src_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic short_end_i,
  input  logic long_hi_i,
  input  logic low_stable_i,
  output src_e src_o
);

  src_e src_q, src_d;

  always_comb begin
    src_d = src_q;
    unique case (src_q)
      SRC_DC:     if (low_stable_i) src_d = SRC_BUS;
      SRC_BUS:    if (long_hi_i) src_d = SRC_DC;
                  else if (short_end_i) src_d = SRC_STROBE;
      SRC_STROBE: if (long_hi_i) src_d = SRC_DC;
      default:    src_d = SRC_DC;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= SRC_DC;
    else         src_q <= src_d;
  end

  assign src_o = src_q;

endmodule

// File: rtl/ctl_src_detect.sv
`timescale 1ns/1ps
module ctl_src_detect
  import ctl_src_pkg::*;
#(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned STROBE_MAX_CYC = 64,
  parameter int unsigned STABLE_CYC     = 160
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       line_a_i,
  input  logic       line_b_i,
  output logic [1:0] src_o,
  output logic [1:0] matrix_mode_o,
  output logic       mute_o
);

  localparam int unsigned CNT_W = $clog2(STABLE_CYC + 1);

  logic rst_sync_n;
  logic [2:0] raw_in, syn_in;
  logic en_s, a_s, b_s;

  ctl_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_sync_n)
  );

  assign raw_in = {en_i, line_a_i, line_b_i};

  ctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .d_i(raw_in), .q_o(syn_in)
  );

  assign {en_s, a_s, b_s} = syn_in;

  logic rise_w, short_end_w, long_hi_w, low_stable_w;

  ctl_level_track #(
    .STROBE_MAX_CYC(STROBE_MAX_CYC), .STABLE_CYC(STABLE_CYC), .CNT_W(CNT_W)
  ) u_track (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .lvl_i(en_s),
    .rise_o(rise_w), .short_end_o(short_end_w),
    .long_hi_o(long_hi_w), .low_stable_o(low_stable_w)
  );

  logic frame_ok_w, mode_cmd_w, mute_cmd_w, mute_val_w;
  mx_e  mode_val_w;

  ctl_strobe_rx u_rx (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .en_i(en_s), .en_rise_i(rise_w),
    .sclk_i(a_s), .sdat_i(b_s),
    .frame_ok_o(frame_ok_w), .mode_cmd_o(mode_cmd_w), .mode_val_o(mode_val_w),
    .mute_cmd_o(mute_cmd_w), .mute_val_o(mute_val_w)
  );

  src_e src_w;

  ctl_src_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .short_end_i(short_end_w),
    .long_hi_i(long_hi_w), .low_stable_i(low_stable_w), .src_o(src_w)
  );

  logic apply_w;
  mx_e  mode_q, mode_d;
  logic mute_q, mute_d;

  assign apply_w = short_end_w & frame_ok_w & (src_w != SRC_DC);

  always_comb begin
    mode_d = mode_q;
    mute_d = mute_q;
    if (src_w == SRC_DC) begin
      mode_d = pair_to_mode(a_s, b_s);
      mute_d = 1'b0;
    end else if (apply_w) begin
      if (mode_cmd_w) mode_d = mode_val_w;
      if (mute_cmd_w) mute_d = mute_val_w;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= MX_MONO;
      mute_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      mute_q <= mute_d;
    end
  end

  assign src_o         = src_w;
  assign matrix_mode_o = mode_q;
  assign mute_o        = mute_q;

endmodule

// File: rtl/ctl_src_detect_chk.sv
`timescale 1ns/1ps
module ctl_src_detect_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] src_o,
  input logic [1:0] matrix_mode_o,
  input logic       mute_o,
  input logic       apply_i,
  input logic       short_end_i
);

  p_src_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_o != 2'd3);

  p_dc_exits_to_bus_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o == 2'd2) |=> (src_o == 2'd2 || src_o == 2'd0));

  p_strobe_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o == 2'd0 && !short_end_i) |=> (src_o != 2'd1));

  p_dc_mute_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o == 2'd2) |=> !mute_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_o != 2'd2 && !apply_i) |=> ($stable(matrix_mode_o) && $stable(mute_o)));

  p_mute_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mute_o) |-> $past(apply_i));

endmodule

bind ctl_src_detect ctl_src_detect_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_o(src_o), .matrix_mode_o(matrix_mode_o),
  .mute_o(mute_o), .apply_i(apply_w), .short_end_i(short_end_w)
);

// File: tb/ctl_src_detect_tb_top.sv
`timescale 1ns/1ps
module ctl_src_detect_tb_top;

  localparam int MAXC   = 64;
  localparam int STABLE = 160;
  localparam logic [6:0] SEL = 7'b1000010;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, en, la, lb;
  logic [1:0] src, mode;
  logic mute;

  ctl_src_detect #(.SYNC_STAGES(2), .STROBE_MAX_CYC(MAXC), .STABLE_CYC(STABLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .line_a_i(la), .line_b_i(lb),
    .src_o(src), .matrix_mode_o(mode), .mute_o(mute)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  event chk_ev;
  logic [1:0] q_src[$];
  logic [1:0] q_mode[$];
  logic       q_mute[$];
  string      q_tag[$];

  // driver side of the scoreboard
  task automatic expect_state(input logic [1:0] s, input logic [1:0] m,
                              input logic mu, input string tag);
    q_src.push_back(s); q_mode.push_back(m); q_mute.push_back(mu); q_tag.push_back(tag);
    ->chk_ev;
    @(negedge clk);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (q_src.size() > 0) begin
        logic [1:0] es, em;
        logic emu;
        string t;
        es = q_src.pop_front(); em = q_mode.pop_front();
        emu = q_mute.pop_front(); t = q_tag.pop_front();
        checks++;
        if (src !== es || mode !== em || mute !== emu) begin
          errors++;
          $display("FAIL %s: src=%0d mode=%0d mute=%0d expected src=%0d mode=%0d mute=%0d",
                   t, src, mode, mute, es, em, emu);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] frame(input logic [6:0] cs, input logic rw,
                                        input logic [2:0] fn, input logic [1:0] d12);
    return {cs, rw, fn, 5'b0, d12, 6'b0};
  endfunction

  // strobe high length = 3 + 2*nbits + pad cycles
  task automatic send(input logic [23:0] w, input int nbits, input int pad);
    en = 1'b1; la = 1'b0; lb = 1'b0;
    idle(2);
    for (int i = 0; i < nbits; i++) begin
      lb = w[23-i]; la = 1'b0;
      idle(1);
      la = 1'b1;
      idle(1);
    end
    la = 1'b0;
    idle(1 + pad);
    en = 1'b0; lb = 1'b0;
    idle(12);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; la = 1'b0; lb = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(1);
    expect_state(2'd2, 2'd0, 1'b0, "R1 reset state");

    // direct decode
    la = 1'b1; lb = 1'b0; idle(8); expect_state(2'd2, 2'd1, 1'b0, "R5 lines 10 stereo");
    la = 1'b0; lb = 1'b1; idle(8); expect_state(2'd2, 2'd2, 1'b0, "R5 lines 01 bilingual");
    la = 1'b1; lb = 1'b1; idle(8); expect_state(2'd2, 2'd3, 1'b0, "R5 lines 11 sub");
    la = 1'b0; lb = 1'b0; idle(8); expect_state(2'd2, 2'd0, 1'b0, "R5 lines 00 mono");

    // low one cycle short of the window
    la = 1'b1; lb = 1'b1; idle(8);
    en = 1'b0; idle(STABLE - 1); en = 1'b1; idle(8);
    expect_state(2'd2, 2'd3, 1'b0, "R2 short low keeps direct");

    en = 1'b0; idle(STABLE + 10);
    expect_state(2'd0, 2'd3, 1'b0, "R2 stable low gives bus");

    la = 1'b0; lb = 1'b1; idle(3); la = 1'b1; lb = 1'b0; idle(3);
    la = 1'b0; lb = 1'b0; idle(8);
    expect_state(2'd0, 2'd3, 1'b0, "R10 line activity with EN low ignored");

    send(frame(SEL, 1'b0, 3'b000, 2'b10), 24, 0);
    expect_state(2'd1, 2'd1, 1'b0, "R4 R6 R7 stereo frame enters strobed");

    send(frame(SEL, 1'b0, 3'b001, 2'b10), 24, 0);
    expect_state(2'd1, 2'd1, 1'b1, "R8 mute on");

    send(frame(7'b1000011, 1'b0, 3'b000, 2'b11), 24, 0);
    expect_state(2'd1, 2'd1, 1'b1, "R9 wrong select code");
    send(frame(SEL, 1'b1, 3'b000, 2'b11), 24, 0);
    expect_state(2'd1, 2'd1, 1'b1, "R9 read direction");
    send(frame(SEL, 1'b0, 3'b000, 2'b11), 23, 0);
    expect_state(2'd1, 2'd1, 1'b1, "R9 short frame");
    send(frame(SEL, 1'b0, 3'b010, 2'b11), 24, 0);
    expect_state(2'd1, 2'd1, 1'b1, "R9 other function");

    send(frame(SEL, 1'b0, 3'b001, 2'b00), 24, 0);
    expect_state(2'd1, 2'd1, 1'b0, "R8 mute off");
    send(frame(SEL, 1'b0, 3'b001, 2'b10), 24, 0);
    send(frame(SEL, 1'b0, 3'b000, 2'b01), 24, 0);
    expect_state(2'd1, 2'd2, 1'b1, "R7 bilingual frame");

    // pulse of exactly MAXC cycles: 51 + 13
    send(frame(SEL, 1'b0, 3'b000, 2'b11), 24, MAXC - 51);
    expect_state(2'd1, 2'd3, 1'b1, "R4 pulse at limit accepted");

    // one cycle more: fallback, frame dropped, lines 00 decode to mono
    send(frame(SEL, 1'b0, 3'b000, 2'b10), 24, MAXC - 50);
    expect_state(2'd2, 2'd0, 1'b0, "R3 overlong strobe falls back");

    en = 1'b0; idle(STABLE + 10);
    expect_state(2'd0, 2'd0, 1'b0, "R2 back to bus, mute cleared");

    en = 1'b1; idle(MAXC + 8);
    expect_state(2'd2, 2'd0, 1'b0, "R3 overlong high from bus");

    en = 1'b0; idle(STABLE + 10);
    en = 1'b1; idle(3); en = 1'b0; idle(10);
    expect_state(2'd1, 2'd0, 1'b0, "R4 R9 empty strobe enters strobed only");

    idle(5);
    done = 1;
    checks++;
    if (q_src.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: pending=%0d expected 0", q_src.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule